// File: doc/BRIEF.md
# Instrument Power Switch Overcurrent Guard

This block owns the enable lines of a bank of instrument power switches. Software opens and closes each switch by writing a small register file. The supply reports overcurrent separately for each channel. The block synchronises and filters each overcurrent report. When a report is qualified on a switch that is fully on, and that channel's override bit is clear, the block opens the switch on its own and latches a sticky trip flag.

Closing a switch starts an inrush guard window. During the window, overcurrent is masked. The window length is programmed in milliseconds. A millisecond is a fixed number of system clocks, set by a shared prescaler. All interfaces are plain level signals: a single-cycle write strobe, a combinational read port, one overcurrent input per channel, and the switch-enable and trip outputs.

Register addresses:
- 0: switch states.
- 1: override mask.
- 2: guard length, in milliseconds.
- 3: trip flags, write-one-to-clear.

Top module: `pwr_guard`

## Requirements
- R1: After reset, every switch is open, every trip flag is clear, and the guard length reads 10.
- R2: A write to address 0 closes channel i at the next clock edge when data bit i is 1. A channel that is already closed stays closed and does not restart its guard. Reading address 0 returns the switch states, and `sw_en` follows them.
- R3: A write to address 0 with data bit i at 0 opens channel i at the next clock edge.
- R4: When a channel is closed, its guard has elapsed, its override is clear and its overcurrent is qualified, the block opens that channel and sets its trip flag. The flag is seen on `trip` and at address 3 bit i. No other channel is affected. Overcurrent on an open channel sets nothing.
- R5: After a switch closes, overcurrent is ignored for L prescaler ticks, where L is the guard length. That is at least (L-1)*CLK_PER_MS+1 and at most L*CLK_PER_MS clocks.
- R6: Bit i of address 1 set to 1 stops channel i from tripping. If the override is cleared while overcurrent persists, the channel trips.
- R7: A write to address 2 stores the written value clamped to the range 10..100. Reads of address 2 return the stored value. The value takes effect at the next switch closure.
- R8: Overcurrent passes a two-flop synchroniser. It counts as qualified only after it is high at two consecutive clock edges, so a pulse seen at a single clock edge has no effect. A persistent overcurrent opens a closed, unmasked switch within 4 clocks.
- R9: A write to address 3 clears each trip flag whose data bit is 1 and leaves the others unchanged. A new trip in the same cycle wins over the clear.
- R10: Closing a tripped channel again starts a fresh guard window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DW | Read data, combinational |
| oc_in | input | NCH | Overcurrent reports from the supply, asynchronous |
| sw_en | output | NCH | Switch enables |
| trip | output | NCH | Sticky trip flags |

## Verification
The bench targets these corner cases and what a faulty design would do in each:
- **Guard edges.** Overcurrent is held from the moment of closure. A guard that is too short opens the switch early; one that never ends never opens it.
- **Pulse filter.** A one-edge overcurrent pulse is compared with a two-edge pulse. A filter that is missing or set one stage too deep trips on the wrong one.
- **Override removal.** The override is released under a standing fault, and a tripped channel is closed again under a standing fault. These catch overrides that do not mask, and guards that fail to restart.
- **Register handling.** Clamp values at both ends of the range and partial write-one-to-clear writes catch wrong limits and flags cleared by zero bits.

Randomly chosen channels, guard lengths, override settings, pulse timings and pulse widths are checked against a bench function that predicts whether each channel trips.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  // Gray-coded channel states; 2'b10 is unused and recovers to CH_OFF
  typedef enum logic [1:0] {
    CH_OFF   = 2'b00,
    CH_GUARD = 2'b01,
    CH_ON    = 2'b11
  } ch_state_e;

  localparam logic [1:0] A_SWITCH   = 2'd0;
  localparam logic [1:0] A_OVERRIDE = 2'd1;
  localparam logic [1:0] A_GUARD    = 2'd2;
  localparam logic [1:0] A_TRIP     = 2'd3;
endpackage

// File: rtl/pwr_guard_tick.sv
module pwr_guard_tick #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_guard_ocfilt.sv
module pwr_guard_ocfilt #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] oc_raw,
  output logic [NCH-1:0] oc_q
);
  logic [NCH-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= oc_raw;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign oc_q = s2 & s3;

  // R8
  oc_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_q != '0) |-> (($past(oc_raw, 2) & $past(oc_raw, 3) & oc_q) == oc_q));
endmodule

// File: rtl/pwr_guard_chan.sv
module pwr_guard_chan
  import pwr_guard_pkg::*;
#(
  parameter int unsigned GW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_on,
  input  logic          cmd_off,
  input  logic          ovr,
  input  logic          oc_q,
  input  logic [GW-1:0] guard_len,
  output logic          sw_en,
  output logic          trip_set
);
  ch_state_e     st;
  logic [GW-1:0] tmr;

  assign trip_set = (st == CH_ON) && oc_q && !ovr;
  assign sw_en    = (st != CH_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= CH_OFF;
      tmr <= '0;
    end else begin
      case (st)
        CH_OFF: if (cmd_on) begin
          st  <= CH_GUARD;
          tmr <= guard_len;
        end
        CH_GUARD: begin
          if (cmd_off) st <= CH_OFF;
          else if (tick) begin
            if (tmr <= GW'(1)) st <= CH_ON;
            else tmr <= tmr - 1'b1;
          end
        end
        CH_ON: if (cmd_off || trip_set) st <= CH_OFF;
        default: st <= CH_OFF;
      endcase
    end
  end

  // R2
  sw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $past(cmd_on));
  // R3
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_off |=> !sw_en);
  // R4
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> ($past(cmd_off) || $past(trip_set)));
  // R5
  guard_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CH_GUARD && !cmd_off) |=> sw_en);
  // R6
  ovr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && ovr && !cmd_off) |=> sw_en);
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter int unsigned NCH        = 4,
  parameter int unsigned DW         = 8,
  parameter int unsigned CLK_PER_MS = 16780,
  parameter int unsigned GMIN       = 10,
  parameter int unsigned GMAX       = 100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [1:0]     rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic [NCH-1:0] oc_in,
  output logic [NCH-1:0] sw_en,
  output logic [NCH-1:0] trip
);
  localparam int unsigned GW = $clog2(GMAX + 1);

  logic           tick;
  logic [NCH-1:0] oc_q, ovr_q, trip_q, trip_set, cmd_on, cmd_off;
  logic [GW-1:0]  glen;

  function automatic logic [GW-1:0] clamp_len(input logic [DW-1:0] v);
    if (v < DW'(GMIN)) return GW'(GMIN);
    if (v > DW'(GMAX)) return GW'(GMAX);
    return GW'(v);
  endfunction

  pwr_guard_tick #(.DIV(CLK_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  pwr_guard_ocfilt #(.NCH(NCH)) u_filt (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_in), .oc_q(oc_q));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cmd_on[i]  = wr_en && (wr_addr == A_SWITCH) &&  wr_data[i];
    assign cmd_off[i] = wr_en && (wr_addr == A_SWITCH) && !wr_data[i];

    pwr_guard_chan #(.GW(GW)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cmd_on(cmd_on[i]), .cmd_off(cmd_off[i]),
      .ovr(ovr_q[i]), .oc_q(oc_q[i]), .guard_len(glen),
      .sw_en(sw_en[i]), .trip_set(trip_set[i]));

    always_ff @(posedge clk) begin
      if (!rst_n) trip_q[i] <= 1'b0;
      else if (trip_set[i]) trip_q[i] <= 1'b1;
      else if (wr_en && wr_addr == A_TRIP && wr_data[i]) trip_q[i] <= 1'b0;
    end

    // R9
    trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(trip_q[i]) |-> $past(wr_en && wr_addr == A_TRIP && wr_data[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q <= '0;
      glen  <= GW'(GMIN);
    end else if (wr_en) begin
      if (wr_addr == A_OVERRIDE) ovr_q <= wr_data[NCH-1:0];
      if (wr_addr == A_GUARD)    glen  <= clamp_len(wr_data);
    end
  end

  assign trip = trip_q;

  always_comb begin
    case (rd_addr)
      A_SWITCH:   rd_data = DW'(sw_en);
      A_OVERRIDE: rd_data = DW'(ovr_q);
      A_GUARD:    rd_data = DW'(glen);
      default:    rd_data = DW'(trip_q);
    endcase
  end

  // R7
  glen_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glen >= GW'(GMIN)) && (glen <= GW'(GMAX)));
endmodule

// File: tb/sim_pwr_guard.sv
module sim_pwr_guard;
  localparam int P = 8;
  localparam int L = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] oc_in = '0;
  logic [3:0] sw_en, trip;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  pwr_guard #(.NCH(4), .DW(8), .CLK_PER_MS(P)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .oc_in(oc_in), .sw_en(sw_en), .trip(trip));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit exp_trip(input bit ovr, input bit late, input int h);
    return !ovr && late && (h >= 2);
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int unsigned seed = $urandom(32'd4242);
    seed = seed + 1;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sw_en", sw_en, 0);
    chk("R1 trip", trip, 0);
    rd(2'd2, v); chk("R1 guard len", v, 10);

    // R7 clamp
    wr(2'd2, 8'd5);   rd(2'd2, v); chk("R7 clamp low", v, 10);
    wr(2'd2, 8'd200); rd(2'd2, v); chk("R7 clamp high", v, 100);
    wr(2'd2, L[7:0]); rd(2'd2, v); chk("R7 in range", v, L);

    // R2 / R3
    wr(2'd0, 8'h5); chk("R2 switch on", sw_en, 4'h5);
    rd(2'd0, v); chk("R2 readback", v, 8'h5);
    wr(2'd0, 8'h0); chk("R3 switch off", sw_en, 0);

    // R4 overcurrent on an open channel is ignored
    oc_in[0] = 1'b1; wait_cyc(10);
    chk("R4 open channel ignores oc", trip, 0);
    oc_in[0] = 1'b0; wait_cyc(4);

    // R5 guard then R4 trip, fault held from closure
    wr(2'd0, 8'h1); oc_in[0] = 1'b1;
    wait_cyc((L-1)*P - 2);
    chk("R5 inside guard", sw_en[0], 1);
    wait_cyc(P + 8);
    chk("R4 tripped open", sw_en[0], 0);
    chk("R4 trip flag", trip, 4'h1);

    // R10 re-enable restarts guard
    wr(2'd0, 8'h1);
    wait_cyc((L-1)*P - 2);
    chk("R10 guard restarted", sw_en[0], 1);
    wait_cyc(P + 8);
    chk("R10 trips after new guard", sw_en[0], 0);
    oc_in[0] = 1'b0; wait_cyc(4);

    // R9 write-one-to-clear
    wr(2'd3, 8'h2); chk("R9 zero bit keeps flag", trip, 4'h1);
    wr(2'd3, 8'h1); rd(2'd3, v); chk("R9 cleared", v, 0);

    // R8 filter
    wr(2'd0, 8'h1); wait_cyc(L*P + 4);
    oc_in[0] = 1'b1; @(negedge clk); oc_in[0] = 1'b0;
    wait_cyc(6);
    chk("R8 single-edge pulse sw", sw_en[0], 1);
    chk("R8 single-edge pulse trip", trip, 0);
    oc_in[0] = 1'b1; wait_cyc(2); oc_in[0] = 1'b0;
    wait_cyc(6);
    chk("R8 two-edge pulse trips", {trip[0], sw_en[0]}, 2'b10);
    wr(2'd3, 8'hF);

    // R6 override
    wr(2'd1, 8'h1); rd(2'd1, v); chk("R6 override readback", v, 8'h1);
    wr(2'd0, 8'h1); oc_in[0] = 1'b1;
    wait_cyc(L*P + 10);
    chk("R6 override holds switch", {trip[0], sw_en[0]}, 2'b01);
    wr(2'd1, 8'h0); wait_cyc(6);
    chk("R6 release trips", {trip[0], sw_en[0]}, 2'b10);
    oc_in[0] = 1'b0; wr(2'd3, 8'hF); wait_cyc(4);

    // Random scenarios, R4/R5/R6/R8
    for (int it = 0; it < 40; it++) begin
      int ch   = $urandom % 4;
      int len  = 10 + $urandom % 21;
      bit ovr  = $urandom % 3 == 0;
      bit late = $urandom % 2;
      int h, d;
      bit e;
      if (late) begin
        h = 1 + $urandom % 4;
        d = len*P + 2 + $urandom % 20;
      end else begin
        h = 1 + $urandom % 5;
        d = $urandom % ((len-1)*P - 6 - h);
      end
      e = exp_trip(ovr, late, h);
      wr(2'd2, len[7:0]);
      wr(2'd1, ovr ? 8'(1 << ch) : 8'h0);
      wr(2'd0, 8'(1 << ch));
      wait_cyc(d);
      oc_in[ch] = 1'b1; wait_cyc(h); oc_in[ch] = 1'b0;
      wait_cyc(6);
      chk("R4 random trip flags", trip, e ? 4'(1 << ch) : 4'h0);
      chk("R5 random switch state", sw_en, e ? 4'h0 : 4'(1 << ch));
      wr(2'd0, 8'h0); wr(2'd3, 8'hF); wr(2'd1, 8'h0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule